// File: doc/BRIEF.md
# Threefish-512 Round-Key Expander

This block turns a 512-bit cipher key and a 128-bit tweak into the round keys of a 512-bit Threefish-style block cipher. When the load strobe is asserted, the block captures the eight key words and the two tweak words. In the same edge it derives two extra words:

- a ninth key word, which is a parity constant XORed with every key word;
- a third tweak word, which is the XOR of the two tweak words.

All eleven words then stay in registers until the next load.

A datapath that runs the cipher rounds asks for round key `s` (0 to 18) by raising a request with that index. One cycle later the block presents the eight 64-bit words of that round key, together with a valid flag. The words rotate through the nine key words, the tweak words enter two fixed lanes, and the index is added into the last lane. Adding the round key to the cipher state is left to the caller.

Top module: `tf_subkey_gen`

## Requirements
- R1: Key word j sits at `key_i[64*j+63:64*j]` (j = 0..7), tweak word j at `tweak_i[64*j+63:64*j]` (j = 0..1), and round-key word i at `subkey_o[64*i+63:64*i]`; all are captured on a clock edge with `load_i` high.
- R2: The ninth key word equals 64'h1BD11BDAA9FC1A22 XOR all eight loaded key words.
- R3: The third tweak word equals tweak word 0 XOR tweak word 1.
- R4: Round-key word i of index s takes extended key word (s+i) mod 9 as its base.
- R5: Word 5 adds extended tweak word s mod 3, and word 6 adds extended tweak word (s+1) mod 3.
- R6: Word 7 adds the index s.
- R7: Every addition wraps modulo 2^64.
- R8: A request with `idx_i` below 19 yields the round key on `subkey_o`, with `valid_o` high, exactly one cycle later.
- R9: A request with `idx_i` of 19 or more raises no `valid_o`, and it leaves `subkey_o` unchanged.
- R10: Without a request, `valid_o` is low and `subkey_o` holds its value. The extended words hold until the next load, so a repeated request returns the same round key.
- R11: A request in the same cycle as a load is served from the previously loaded key and tweak.
- R12: After reset, `valid_o` is 0 and `subkey_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Capture key and tweak, and derive the extended words |
| key_i | input | 512 | Eight key words, word 0 in the low bits |
| tweak_i | input | 128 | Two tweak words, word 0 in the low bits |
| req_i | input | 1 | Request one round key |
| idx_i | input | 5 | Round-key index s |
| subkey_o | output | 512 | Eight round-key words, word 0 in the low bits |
| valid_o | output | 1 | Round key on `subkey_o` belongs to the previous cycle's request |

## Verification
The directed tests cover indices 0, 5, 9 and 18, where the mod-9 and mod-3 rotations wrap or realign. A design that mis-rotated would shift a key word into the wrong lane, or put the wrong tweak word in lanes 5 and 6. All-ones key and tweak words force carries out of bit 63, which exposes any sum that is not truncated. Indices 19 and 31 are requested to catch a design that answers out-of-range requests or disturbs the held output. A request issued in the same cycle as a load catches a design that lets the new key leak into that answer.

// File: rtl/tfk_pkg.sv
package tfk_pkg;
  localparam int WW      = 64;
  localparam int NKW     = 8;
  localparam int NTW     = 2;
  localparam int NK_EXT  = NKW + 1;
  localparam int NT_EXT  = NTW + 1;
  localparam int KEY_BITS = NKW * WW;
  localparam int TWK_BITS = NTW * WW;
  localparam logic [WW-1:0] PARITY_C = 64'h1BD1_1BDA_A9FC_1A22;
  localparam int TW_LANE_A = NKW - 3;
  localparam int TW_LANE_B = NKW - 2;
  localparam int IDX_LANE  = NKW - 1;

  typedef logic [WW-1:0] word_t;
endpackage

// File: rtl/tfk_rst_sync.sv
module tfk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tfk_extend.sv
module tfk_extend
  import tfk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [KEY_BITS-1:0] key_i,
  input  logic [TWK_BITS-1:0] tweak_i,
  output word_t               ks_o [NK_EXT],
  output word_t               ts_o [NT_EXT]
);
  word_t ks_d [NK_EXT];
  word_t ts_d [NT_EXT];
  word_t ks_q [NK_EXT];
  word_t ts_q [NT_EXT];

  // next-state: raw words plus derived parity/tweak words
  always_comb begin
    word_t par;
    word_t tx;
    par = PARITY_C;
    tx  = '0;
    for (int i = 0; i < NKW; i++) begin
      ks_d[i] = key_i[i*WW +: WW];
      par     = par ^ key_i[i*WW +: WW];
    end
    ks_d[NKW] = par;
    for (int j = 0; j < NTW; j++) begin
      ts_d[j] = tweak_i[j*WW +: WW];
      tx      = tx ^ tweak_i[j*WW +: WW];
    end
    ts_d[NTW] = tx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NK_EXT; i++) ks_q[i] <= '0;
      for (int j = 0; j < NT_EXT; j++) ts_q[j] <= '0;
    end else if (load_i) begin
      for (int i = 0; i < NK_EXT; i++) ks_q[i] <= ks_d[i];
      for (int j = 0; j < NT_EXT; j++) ts_q[j] <= ts_d[j];
    end
  end

  assign ks_o = ks_q;
  assign ts_o = ts_q;
endmodule

// File: rtl/tfk_word_sel.sv
module tfk_word_sel
  import tfk_pkg::*;
#(
  parameter int LANE  = 0,
  parameter int IDX_W = 5
) (
  input  word_t             ks_i [NK_EXT],
  input  word_t             ts_i [NT_EXT],
  input  logic [IDX_W-1:0]  s_i,
  output word_t             w_o
);
  localparam bit ADD_TW  = (LANE == TW_LANE_A) || (LANE == TW_LANE_B);
  localparam int TW_OFS  = (LANE == TW_LANE_B) ? 1 : 0;
  localparam bit ADD_IDX = (LANE == IDX_LANE);

  logic [31:0] kx;
  logic [31:0] tx;
  word_t       base;
  word_t       tw_term;
  word_t       idx_term;

  always_comb begin
    kx       = (32'(s_i) + 32'(LANE)) % 32'(NK_EXT);
    tx       = (32'(s_i) + 32'(TW_OFS)) % 32'(NT_EXT);
    base     = ks_i[kx[3:0]];
    tw_term  = ADD_TW  ? ts_i[tx[1:0]] : '0;
    idx_term = ADD_IDX ? WW'(s_i)      : '0;
    w_o      = base + tw_term + idx_term;
  end
endmodule

// File: rtl/tf_subkey_gen.sv
module tf_subkey_gen
  import tfk_pkg::*;
#(
  parameter int NUM_SUBKEYS = 19,
  parameter int IDX_W       = $clog2(NUM_SUBKEYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [KEY_BITS-1:0] key_i,
  input  logic [TWK_BITS-1:0] tweak_i,
  input  logic                req_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [KEY_BITS-1:0] subkey_o,
  output logic                valid_o
);
  logic                rst_s_n;
  word_t               ks_w [NK_EXT];
  word_t               ts_w [NT_EXT];
  logic [KEY_BITS-1:0] sk_cmb;
  logic [KEY_BITS-1:0] sk_d;
  logic [KEY_BITS-1:0] sk_q;
  logic                vld_d;
  logic                vld_q;
  logic                take;

  tfk_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  tfk_extend u_ext (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .load_i  (load_i),
    .key_i   (key_i),
    .tweak_i (tweak_i),
    .ks_o    (ks_w),
    .ts_o    (ts_w)
  );

  for (genvar g = 0; g < NKW; g++) begin : g_lane
    tfk_word_sel #(.LANE(g), .IDX_W(IDX_W)) u_sel (
      .ks_i (ks_w),
      .ts_i (ts_w),
      .s_i  (idx_i),
      .w_o  (sk_cmb[g*WW +: WW])
    );
  end

  always_comb begin
    take  = req_i && (32'(idx_i) < 32'(NUM_SUBKEYS));
    vld_d = take;
    sk_d  = take ? sk_cmb : sk_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      sk_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (take) sk_q <= sk_d;
    end
  end

  assign subkey_o = sk_q;
  assign valid_o  = vld_q;
endmodule

// File: rtl/tfk_chk.sv
module tfk_chk
  import tfk_pkg::*;
#(
  parameter int NUM_SUBKEYS = 19,
  parameter int IDX_W       = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                load_i,
  input logic [KEY_BITS-1:0] key_i,
  input logic [TWK_BITS-1:0] tweak_i,
  input logic                req_i,
  input logic [IDX_W-1:0]    idx_i,
  input logic [KEY_BITS-1:0] subkey_o,
  input logic                valid_o,
  input word_t               k_ext,
  input word_t               t_ext
);
  function automatic word_t fold_key(input logic [KEY_BITS-1:0] k);
    word_t r;
    r = PARITY_C;
    for (int i = 0; i < NKW; i++) r = r ^ k[i*WW +: WW];
    return r;
  endfunction

  logic in_rng;
  assign in_rng = 32'(idx_i) < 32'(NUM_SUBKEYS);

  p_valid_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && in_rng) |=> valid_o);

  p_oob_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !in_rng) |=> (!valid_o && $stable(subkey_o)));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (!valid_o && $stable(subkey_o)));

  p_parity_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (k_ext == fold_key($past(key_i))));

  p_tweak_xor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (t_ext == ($past(tweak_i[WW-1:0]) ^ $past(tweak_i[2*WW-1:WW]))));

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_r12: assert (!valid_o);
    end
  end
endmodule

bind tf_subkey_gen tfk_chk #(.NUM_SUBKEYS(NUM_SUBKEYS), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_s_n),
  .load_i   (load_i),
  .key_i    (key_i),
  .tweak_i  (tweak_i),
  .req_i    (req_i),
  .idx_i    (idx_i),
  .subkey_o (subkey_o),
  .valid_o  (valid_o),
  .k_ext    (ks_w[tfk_pkg::NKW]),
  .t_ext    (ts_w[tfk_pkg::NTW])
);

// File: tb/sim_tf_subkey_gen.sv
module sim_tf_subkey_gen;
  logic         clk;
  logic         rst_n;
  logic         load_i;
  logic [511:0] key_i;
  logic [127:0] tweak_i;
  logic         req_i;
  logic [4:0]   idx_i;
  logic [511:0] subkey_o;
  logic         valid_o;

  int n_chk;
  int n_bad;
  logic [63:0] mk [9];
  logic [63:0] mt [3];

  tf_subkey_gen u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .key_i(key_i), .tweak_i(tweak_i),
    .req_i(req_i), .idx_i(idx_i), .subkey_o(subkey_o), .valid_o(valid_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // reference model built from the requirements
  task automatic model_set(input logic [511:0] k, input logic [127:0] t);
    logic [63:0] p;
    p = 64'h1BD11BDAA9FC1A22;
    for (int i = 0; i < 8; i++) begin
      mk[i] = k[i*64 +: 64];
      p = p ^ mk[i];
    end
    mk[8] = p;
    mt[0] = t[63:0];
    mt[1] = t[127:64];
    mt[2] = mt[0] ^ mt[1];
  endtask

  function automatic logic [511:0] exp_sk(input int s);
    logic [511:0] r;
    logic [63:0]  w;
    for (int i = 0; i < 8; i++) begin
      w = mk[(s + i) % 9];
      if (i == 5) w = w + mt[s % 3];
      if (i == 6) w = w + mt[(s + 1) % 3];
      if (i == 7) w = w + 64'(s);
      r[i*64 +: 64] = w;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [511:0] got, input logic [511:0] exp,
                       input logic gv, input logic ev);
    n_chk++;
    if (got !== exp || gv !== ev) begin
      n_bad++;
      $display("FAIL %s: got valid=%b data=%h expected valid=%b data=%h", req, gv, got, ev, exp);
    end
  endtask

  task automatic do_load(input logic [511:0] k, input logic [127:0] t);
    @(negedge clk);
    load_i = 1'b1; key_i = k; tweak_i = t;
    @(negedge clk);
    load_i = 1'b0;
    model_set(k, t);
  endtask

  task automatic ask(input string req, input int s);
    @(negedge clk);
    req_i = 1'b1; idx_i = 5'(s);
    @(negedge clk);
    req_i = 1'b0;
    check(req, subkey_o, exp_sk(s), valid_o, 1'b1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; load_i = 1'b0; req_i = 1'b0; idx_i = '0; key_i = '0; tweak_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 reset", subkey_o, '0, valid_o, 1'b0);
  endtask

  task automatic t_pattern_a;
    logic [511:0] k;
    logic [127:0] t;
    for (int i = 0; i < 8; i++) k[i*64 +: 64] = 64'h0101_0101_0101_0101 * 64'(i + 1) ^ 64'hA5A5_0000_5A5A_0000;
    t = {64'h0F0E_0D0C_0B0A_0908, 64'h0706_0504_0302_0100};
    do_load(k, t);
    ask("R1 R4 s=0", 0);
    ask("R2 R4 R5 s=5", 5);
    ask("R3 R5 R6 s=9", 9);
    ask("R4 R6 s=18", 18);
    ask("R5 s=1", 1);
  endtask

  task automatic t_out_of_range;
    logic [511:0] held;
    held = subkey_o;
    @(negedge clk);
    req_i = 1'b1; idx_i = 5'd19;
    @(negedge clk);
    req_i = 1'b0;
    check("R9 idx=19", subkey_o, held, valid_o, 1'b0);
    @(negedge clk);
    req_i = 1'b1; idx_i = 5'd31;
    @(negedge clk);
    req_i = 1'b0;
    check("R9 idx=31", subkey_o, held, valid_o, 1'b0);
  endtask

  task automatic t_hold;
    logic [511:0] held;
    held = subkey_o;
    repeat (5) @(negedge clk);
    check("R10 idle hold", subkey_o, held, valid_o, 1'b0);
    ask("R10 repeat s=18", 18);
  endtask

  task automatic t_wrap;
    do_load({8{64'hFFFF_FFFF_FFFF_FFFF}}, {2{64'hFFFF_FFFF_FFFF_FFF0}});
    ask("R7 wrap s=0", 0);
    ask("R7 wrap s=17", 17);
  endtask

  task automatic t_load_and_req;
    logic [511:0] k2;
    logic [127:0] t2;
    logic [511:0] e;
    for (int i = 0; i < 8; i++) k2[i*64 +: 64] = 64'h1357_9BDF_2468_ACE0 + 64'(i * 7919);
    t2 = {64'hDEAD_BEEF_0000_1111, 64'h1234_5678_9ABC_DEF0};
    e = exp_sk(3);
    @(negedge clk);
    load_i = 1'b1; key_i = k2; tweak_i = t2; req_i = 1'b1; idx_i = 5'd3;
    @(negedge clk);
    load_i = 1'b0; req_i = 1'b0;
    check("R11 old key served", subkey_o, e, valid_o, 1'b1);
    model_set(k2, t2);
    ask("R1 R11 new key s=3", 3);
    ask("R4 new key s=8", 8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    t_reset();
    t_pattern_a();
    t_out_of_range();
    t_hold();
    t_wrap();
    t_load_and_req();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule